// File: doc/BRIEF.md
# Audio Transmit Sample FIFO with Packing

This block is the transmit sample store for one playback channel of an AC'97-style audio link. Each register write delivers a 32-bit word, which a formatter turns into either one sample or, in packed mode, two 16-bit-or-narrower samples. Every sample is left-aligned into a 20-bit slot before it is stored. Because every entry holds exactly one slot, the fill level does not depend on the packing mode.

The store is drained toward a codec sample port in stereo pairs: left is the older entry and right the newer. Draining begins only once the store is at least half full. A drain burst then moves one pair per cycle for as long as the codec accepts. The block keeps sticky empty, half-empty, full and underrun flags. It derives three interrupt status bits from them and drives a masked interrupt line. Clearing the interface enable returns the store and its flags to the reset state.

Top module: `audio_tx_fifo`

## Requirements
- R1: After reset the level is 0, empty=1, half-empty=1, full=0, underrun=0 and no pair is offered.
- R2: In unpacked mode a write stores one slot. The size code selects the layout: 0 gives a 16-bit sample shifted left by 4, 1 gives 18-bit shifted by 2, 2 gives 20-bit unchanged and 3 gives 12-bit shifted by 8. Each result is taken as 20 bits.
- R3: In packed mode with size code 0 or 3, a write stores two slots. Bits 15:0 are stored first and bits 31:16 second, each shifted left by 4 (code 0) or 8 (code 3) and truncated to 20 bits.
- R4: Packed mode requested with size code 1 or 2 falls back to unpacked storage of one slot.
- R5: An unpacked write arriving when the level equals DEPTH is dropped, and the level and stored data are unchanged.
- R6: A packed write is accepted only when level+2 is strictly below DEPTH; otherwise it is dropped.
- R7: After a push, a nonzero level clears empty and underrun. A level of at least DEPTH/2 clears half-empty, and a level of DEPTH or more sets full.
- R8: A pair is offered only when all of these hold: the interface is enabled, transmit is enabled, at least one slot-select bit is set, the level is at least 2, and either the level is at least DEPTH/2 or a burst is in progress.
- R9: While the codec accepts, a burst removes one pair per cycle until fewer than 2 entries remain. A refused pair ends the burst, and below DEPTH/2 no new burst starts.
- R10: A removed pair clears full. A resulting level of at most DEPTH/2 sets half-empty, and a resulting level of 0 sets both empty and underrun.
- R11: The interrupt status has bit 0 = transmit complete (empty and no pair offered), bit 1 = half-empty and bit 2 = underrun. The interrupt line is the OR of the status ANDed with the mask.
- R12: A pulse on the underrun-clear input clears underrun and leaves the other flags unchanged.
- R13: While the interface enable is low, the store is flushed, the flags hold their reset values and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ifEnable | input | 1 | Interface enable; low flushes the store |
| txEnable | input | 1 | Transmit enable for draining |
| slotSel | input | 2 | Output slot selection; any set bit permits draining |
| sizeSel | input | 2 | Sample size code (0=16, 1=18, 2=20, 3=12 bits) |
| packEn | input | 1 | Request two samples per write |
| wrValid | input | 1 | Data word write strobe |
| wrData | input | 32 | Written data word |
| clrUnderrun | input | 1 | Underrun clear pulse |
| intMask | input | 3 | Interrupt enable mask |
| codecReady | input | 1 | Codec accepts the offered pair |
| pairValid | output | 1 | A pair is offered |
| pairLeft | output | 20 | Left (older) slot |
| pairRight | output | 20 | Right (newer) slot |
| level | output | $clog2(DEPTH+1) | Entries stored |
| emptyFlag | output | 1 | Empty flag |
| halfEmptyFlag | output | 1 | Half-empty flag |
| fullFlag | output | 1 | Full flag |
| underrunFlag | output | 1 | Underrun flag |
| intStatus | output | 3 | Interrupt status bits |
| irq | output | 1 | Masked interrupt line |

## Verification
The bench builds the block with the default DEPTH of 8, so the half-full drain point is 4 entries. At that depth a full store and the packed ceiling of 6 entries can each be reached in a handful of writes. A burst that starts at 8 crosses below the half point and shows that a running burst continues to empty. A single accepted pair from 4 followed by a refusal leaves 2 entries, which shows that a stalled drain below half does not restart.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;
  localparam int SLOT_W = 20;

  typedef enum logic [1:0] {
    SZ16 = 2'd0,
    SZ18 = 2'd1,
    SZ20 = 2'd2,
    SZ12 = 2'd3
  } sampleSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic pushOne;
    logic pushTwo;
    logic popPair;
    logic flush;
  } fifoCtl_t;
endpackage

// File: rtl/audio_tx_slot_fmt.sv
module audio_tx_slot_fmt
  import audio_tx_pkg::*;
(
  input  logic [31:0]       wrData,
  input  logic [1:0]        sizeSel,
  input  logic              packReq,
  output logic [SLOT_W-1:0] sampleA,
  output logic [SLOT_W-1:0] sampleB,
  output logic              twoSamples
);
  sampleSize_e sz;
  logic [15:0] lowHalf;
  logic [15:0] highHalf;

  assign sz       = sampleSize_e'(sizeSel);
  assign lowHalf  = wrData[15:0];
  assign highHalf = wrData[31:16];

  // packing only meaningful for 12/16-bit samples (R4)
  assign twoSamples = packReq && ((sz == SZ16) || (sz == SZ12));

  always_comb begin
    sampleA = '0;
    sampleB = '0;
    if (twoSamples) begin
      if (sz == SZ12) begin
        sampleA = {lowHalf[11:0], 8'h00};
        sampleB = {highHalf[11:0], 8'h00};
      end else begin
        sampleA = {lowHalf, 4'h0};
        sampleB = {highHalf, 4'h0};
      end
    end else begin
      unique case (sz)
        SZ12:    sampleA = {wrData[11:0], 8'h00};
        SZ16:    sampleA = {wrData[15:0], 4'h0};
        SZ18:    sampleA = {wrData[17:0], 2'b00};
        default: sampleA = wrData[19:0];
      endcase
    end
  end
endmodule

// File: rtl/audio_tx_datapath.sv
module audio_tx_datapath
  import audio_tx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCtl_t          ctl,
  input  logic [SLOT_W-1:0] sampleA,
  input  logic [SLOT_W-1:0] sampleB,
  output logic [LW-1:0]     level,
  output logic [LW-1:0]     levelNext,
  output logic [SLOT_W-1:0] pairLeft,
  output logic [SLOT_W-1:0] pairRight
);
  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

  logic [SLOT_W-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr;
  logic [PW-1:0] rdPtr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p, input int unsigned n);
    int unsigned t;
    t = int'(p) + n;
    if (t >= DEPTH) t = t - DEPTH;
    return PW'(t);
  endfunction

  always_comb begin
    levelNext = level;
    if (ctl.flush) begin
      levelNext = '0;
    end else begin
      if (ctl.pushOne) levelNext = levelNext + LW'(1);
      if (ctl.pushTwo) levelNext = levelNext + LW'(2);
      if (ctl.popPair) levelNext = levelNext - LW'(2);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (ctl.flush) begin
      level <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      level <= levelNext;
      if (ctl.pushOne) wrPtr <= bump(wrPtr, 1);
      if (ctl.pushTwo) wrPtr <= bump(wrPtr, 2);
      if (ctl.popPair) rdPtr <= bump(rdPtr, 2);
    end
  end

  always_ff @(posedge clk) begin
    if (!ctl.flush) begin
      if (ctl.pushOne || ctl.pushTwo) mem[wrPtr] <= sampleA;
      if (ctl.pushTwo) mem[bump(wrPtr, 1)] <= sampleB;
    end
  end

  assign pairLeft  = mem[rdPtr];
  assign pairRight = mem[bump(rdPtr, 1)];

  // R5: storage never holds more than DEPTH entries
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    level <= DEPTH_L);

  // R13: a flush strobe leaves the store empty
  a_r13_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |=> (level == '0));
endmodule

// File: rtl/audio_tx_ctrl.sv
module audio_tx_ctrl
  import audio_tx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ifEnable,
  input  logic          txEnable,
  input  logic [1:0]    slotSel,
  input  logic          wrValid,
  input  logic          twoSamples,
  input  logic          clrUnderrun,
  input  logic [2:0]    intMask,
  input  logic          codecReady,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] levelNext,
  output fifoCtl_t      ctl,
  output logic          pairValid,
  output logic          emptyFlag,
  output logic          halfEmptyFlag,
  output logic          fullFlag,
  output logic          underrunFlag,
  output logic [2:0]    intStatus,
  output logic          irq
);
  localparam int LX = LW + 1;
  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);
  localparam logic [LW-1:0] HALF_L  = LW'(DEPTH / 2);
  localparam logic [LW-1:0] TWO_L   = LW'(2);

  logic draining;
  logic drainAllowed;
  logic anyPush;
  logic txComplete;

  assign drainAllowed = ifEnable && txEnable && (|slotSel);
  assign pairValid    = drainAllowed && (level >= TWO_L) && (draining || (level >= HALF_L));

  always_comb begin
    ctl         = '0;
    ctl.flush   = !ifEnable;
    ctl.pushOne = ifEnable && wrValid && !twoSamples && (level < DEPTH_L);
    ctl.pushTwo = ifEnable && wrValid && twoSamples &&
                  ((LX'(level) + LX'(2)) < LX'(DEPTH));
    ctl.popPair = pairValid && codecReady;
  end

  assign anyPush = ctl.pushOne || ctl.pushTwo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      emptyFlag     <= 1'b1;
      halfEmptyFlag <= 1'b1;
      fullFlag      <= 1'b0;
      underrunFlag  <= 1'b0;
      draining      <= 1'b0;
    end else if (ctl.flush) begin
      emptyFlag     <= 1'b1;
      halfEmptyFlag <= 1'b1;
      fullFlag      <= 1'b0;
      underrunFlag  <= 1'b0;
      draining      <= 1'b0;
    end else begin
      if (clrUnderrun) underrunFlag <= 1'b0;
      if (ctl.popPair) begin
        fullFlag <= 1'b0;
        if (levelNext <= HALF_L) halfEmptyFlag <= 1'b1;
        if (levelNext == '0) begin
          emptyFlag    <= 1'b1;
          underrunFlag <= 1'b1;
        end
      end
      if (anyPush) begin
        if (levelNext != '0) begin
          emptyFlag    <= 1'b0;
          underrunFlag <= 1'b0;
        end
        if (levelNext >= HALF_L) halfEmptyFlag <= 1'b0;
        if (levelNext >= DEPTH_L) fullFlag <= 1'b1;
      end
      draining <= ctl.popPair && (levelNext >= TWO_L);
    end
  end

  assign txComplete = !pairValid && emptyFlag;
  assign intStatus  = {underrunFlag, halfEmptyFlag, txComplete};
  assign irq        = |(intStatus & intMask);

  // R8: a pair is never offered with fewer than two stored entries
  a_r8_pair_needs_two: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |-> (level >= TWO_L));

  // R10: an accepted pair leaves the full flag cleared
  a_r10_pop_clears_full: assert property (@(posedge clk) disable iff (!rstN)
    ctl.popPair |=> !fullFlag);

  // R7: the empty flag is only ever seen with nothing stored
  a_r7_empty_means_zero: assert property (@(posedge clk) disable iff (!rstN)
    emptyFlag |-> (level == '0));

  // R12: a clear pulse without a drain leaves underrun low
  a_r12_clear_underrun: assert property (@(posedge clk) disable iff (!rstN)
    (clrUnderrun && !ctl.popPair) |=> !underrunFlag);
endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
  import audio_tx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       ifEnable,
  input  logic                       txEnable,
  input  logic [1:0]                 slotSel,
  input  logic [1:0]                 sizeSel,
  input  logic                       packEn,
  input  logic                       wrValid,
  input  logic [31:0]                wrData,
  input  logic                       clrUnderrun,
  input  logic [2:0]                 intMask,
  input  logic                       codecReady,
  output logic                       pairValid,
  output logic [19:0]                pairLeft,
  output logic [19:0]                pairRight,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       emptyFlag,
  output logic                       halfEmptyFlag,
  output logic                       fullFlag,
  output logic                       underrunFlag,
  output logic [2:0]                 intStatus,
  output logic                       irq
);
  localparam int LW = $clog2(DEPTH + 1);

  fifoCtl_t          ctl;
  logic [SLOT_W-1:0] sampleA;
  logic [SLOT_W-1:0] sampleB;
  logic              twoSamples;
  logic [LW-1:0]     levelNext;

  audio_tx_slot_fmt u_fmt (
    .wrData     (wrData),
    .sizeSel    (sizeSel),
    .packReq    (packEn),
    .sampleA    (sampleA),
    .sampleB    (sampleB),
    .twoSamples (twoSamples)
  );

  audio_tx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .ifEnable      (ifEnable),
    .txEnable      (txEnable),
    .slotSel       (slotSel),
    .wrValid       (wrValid),
    .twoSamples    (twoSamples),
    .clrUnderrun   (clrUnderrun),
    .intMask       (intMask),
    .codecReady    (codecReady),
    .level         (level),
    .levelNext     (levelNext),
    .ctl           (ctl),
    .pairValid     (pairValid),
    .emptyFlag     (emptyFlag),
    .halfEmptyFlag (halfEmptyFlag),
    .fullFlag      (fullFlag),
    .underrunFlag  (underrunFlag),
    .intStatus     (intStatus),
    .irq           (irq)
  );

  audio_tx_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .sampleA   (sampleA),
    .sampleB   (sampleB),
    .level     (level),
    .levelNext (levelNext),
    .pairLeft  (pairLeft),
    .pairRight (pairRight)
  );
endmodule

// File: tb/audio_tx_fifo_bench.sv
`timescale 1ns/1ps
module audio_tx_fifo_bench;
  localparam int DEPTH = 8;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ifEnable = 1'b1, txEnable = 1'b0, packEn = 1'b0, wrValid = 1'b0;
  logic [1:0] slotSel = 2'b00, sizeSel = 2'd0;
  logic [31:0] wrData = '0;
  logic clrUnderrun = 1'b0, codecReady = 1'b0;
  logic [2:0] intMask = 3'b000;
  logic pairValid, emptyFlag, halfEmptyFlag, fullFlag, underrunFlag, irq;
  logic [19:0] pairLeft, pairRight;
  logic [LW-1:0] level;
  logic [2:0] intStatus;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  audio_tx_fifo #(.DEPTH(DEPTH)) u_audio_tx_fifo (
    .clk(clk), .rstN(rstN), .ifEnable(ifEnable), .txEnable(txEnable),
    .slotSel(slotSel), .sizeSel(sizeSel), .packEn(packEn), .wrValid(wrValid),
    .wrData(wrData), .clrUnderrun(clrUnderrun), .intMask(intMask),
    .codecReady(codecReady), .pairValid(pairValid), .pairLeft(pairLeft),
    .pairRight(pairRight), .level(level), .emptyFlag(emptyFlag),
    .halfEmptyFlag(halfEmptyFlag), .fullFlag(fullFlag),
    .underrunFlag(underrunFlag), .intStatus(intStatus), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic writeWord(input logic [31:0] d);
    @(negedge clk);
    wrData = d;
    wrValid = 1'b1;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic flushFifo();
    @(negedge clk);
    ifEnable = 1'b0;
    txEnable = 1'b0;
    codecReady = 1'b0;
    slotSel = 2'b00;
    packEn = 1'b0;
    @(negedge clk);
    ifEnable = 1'b1;
  endtask

  task automatic testReset();
    #1;
    check("R1 level", 32'(level), 0);
    check("R1 flags", {emptyFlag, halfEmptyFlag, fullFlag, underrunFlag}, 4'b1100);
    check("R1 pairValid", 32'(pairValid), 0);
    check("R11 status after reset", 32'(intStatus), 3'b011);
  endtask

  task automatic testUnpacked();
    flushFifo();
    sizeSel = 2'd3; writeWord(32'hFFFF_FABC);
    sizeSel = 2'd0; writeWord(32'hFFFF_1234);
    check("R2 12-bit slot", 32'(pairLeft), 32'hABC00);
    check("R2 16-bit slot", 32'(pairRight), 32'h12340);
    flushFifo();
    sizeSel = 2'd1; writeWord(32'h0003_FFFF);
    sizeSel = 2'd2; writeWord(32'hFFF1_2345);
    check("R2 18-bit slot", 32'(pairLeft), 32'hFFFFC);
    check("R2 20-bit slot", 32'(pairRight), 32'h12345);
    check("R7 level 2", 32'(level), 2);
    check("R7 empty cleared", 32'(emptyFlag), 0);
    check("R7 half-empty kept", 32'(halfEmptyFlag), 1);
  endtask

  task automatic testPacked();
    flushFifo();
    packEn = 1'b1; sizeSel = 2'd0;
    writeWord(32'hBEEF_1234);
    check("R3 16 low first", 32'(pairLeft), 32'h12340);
    check("R3 16 high second", 32'(pairRight), 32'hBEEF0);
    check("R3 level", 32'(level), 2);
    flushFifo();
    packEn = 1'b1; sizeSel = 2'd3;
    writeWord(32'h0ABC_0DEF);
    check("R3 12 low first", 32'(pairLeft), 32'hDEF00);
    check("R3 12 high second", 32'(pairRight), 32'hABC00);
    flushFifo();
    packEn = 1'b1; sizeSel = 2'd2;
    writeWord(32'h0005_4321);
    check("R4 fallback level", 32'(level), 1);
    check("R4 fallback slot", 32'(pairLeft), 32'h54321);
  endtask

  task automatic testOverrun();
    flushFifo();
    sizeSel = 2'd2;
    for (int i = 1; i <= DEPTH; i++) begin
      writeWord(32'(i * 32'h11111));
      if (i == DEPTH / 2 - 1) check("R7 half-empty below half", 32'(halfEmptyFlag), 1);
      if (i == DEPTH / 2) check("R7 half-empty cleared", 32'(halfEmptyFlag), 0);
    end
    check("R7 full set", 32'(fullFlag), 1);
    writeWord(32'h000F_FFFF);
    check("R5 level held", 32'(level), DEPTH);
    check("R5 oldest kept", 32'(pairLeft), 32'h11111);
    flushFifo();
    packEn = 1'b1; sizeSel = 2'd0;
    for (int i = 0; i < 4; i++) writeWord(32'h1111_2222);
    check("R6 packed ceiling", 32'(level), DEPTH - 2);
    check("R6 not full", 32'(fullFlag), 0);
  endtask

  task automatic testDrain();
    flushFifo();
    sizeSel = 2'd2;
    for (int i = 1; i <= DEPTH; i++) writeWord(32'(i * 32'h11111));
    @(negedge clk);
    slotSel = 2'b10; txEnable = 1'b1; codecReady = 1'b1;
    #1;
    for (int k = 0; k < DEPTH / 2; k++) begin
      check("R9 pair offered", 32'(pairValid), 1);
      check("R8 left older", 32'(pairLeft), 32'((2 * k + 1) * 32'h11111));
      check("R8 right newer", 32'(pairRight), 32'((2 * k + 2) * 32'h11111));
      @(negedge clk);
    end
    check("R9 burst emptied", 32'(level), 0);
    check("R10 flags after drain", {emptyFlag, halfEmptyFlag, fullFlag, underrunFlag}, 4'b1101);
    check("R11 status all set", 32'(intStatus), 3'b111);
    codecReady = 1'b0; txEnable = 1'b0;
    intMask = 3'b100; #1;
    check("R11 irq underrun", 32'(irq), 1);
    @(negedge clk); clrUnderrun = 1'b1;
    @(negedge clk); clrUnderrun = 1'b0; #1;
    check("R12 underrun cleared", 32'(underrunFlag), 0);
    check("R12 empty kept", 32'(emptyFlag), 1);
    check("R11 irq masked off", 32'(irq), 0);
    intMask = 3'b001; #1;
    check("R11 irq complete", 32'(irq), 1);
    intMask = 3'b000; #1;
    check("R11 irq zero mask", 32'(irq), 0);
  endtask

  task automatic testGateAndRefuse();
    flushFifo();
    sizeSel = 2'd2; txEnable = 1'b1; codecReady = 1'b1; slotSel = 2'b00;
    for (int i = 0; i < DEPTH / 2; i++) writeWord(32'h00ABC);
    @(negedge clk);
    check("R8 no slot no drain", 32'(level), DEPTH / 2);
    txEnable = 1'b0; slotSel = 2'b01;
    @(negedge clk); #1;
    check("R8 tx off no offer", 32'(pairValid), 0);
    check("R8 tx off no drain", 32'(level), DEPTH / 2);
    txEnable = 1'b1; codecReady = 1'b1;
    @(negedge clk);
    codecReady = 1'b0; #1;
    check("R9 one pair taken", 32'(level), DEPTH / 2 - 2);
    check("R9 burst still offers", 32'(pairValid), 1);
    @(negedge clk); #1;
    check("R9 refusal ends burst", 32'(pairValid), 0);
    codecReady = 1'b1;
    @(negedge clk); #1;
    check("R9 no restart below half", 32'(level), DEPTH / 2 - 2);
    check("R10 partial flags", {emptyFlag, halfEmptyFlag, fullFlag, underrunFlag}, 4'b0100);
  endtask

  task automatic testDisable();
    flushFifo();
    sizeSel = 2'd2;
    for (int i = 0; i < 5; i++) writeWord(32'h00123);
    @(negedge clk); ifEnable = 1'b0;
    wrValid = 1'b1; wrData = 32'h00456;
    @(negedge clk); @(negedge clk);
    wrValid = 1'b0; #1;
    check("R13 flushed", 32'(level), 0);
    check("R13 flags reset", {emptyFlag, halfEmptyFlag, fullFlag, underrunFlag}, 4'b1100);
    ifEnable = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testUnpacked();
    testPacked();
    testOverrun();
    testDrain();
    testGateAndRefuse();
    testDisable();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule